// File: doc/BRIEF.md
# Double-Precision NaN Quieting Unit

This block takes one 64-bit IEEE 754 double-precision operand and sorts it into one of six classes: zero, denormal, normal, infinity, quiet NaN or signaling NaN. When the operand is a signaling NaN, the block produces the quiet NaN that stands in for it and raises an invalid-operation flag. Every other operand passes through untouched. A floating-point datapath places it ahead of any stage that has to turn signaling inputs into quiet results.

A mode input selects how the top fraction bit is read. Under the 2008 encoding, a clear top fraction bit marks a signaling NaN, and quieting sets that bit. Under the legacy encoding, a set top fraction bit marks a signaling NaN, and quieting clears it. In legacy mode, clearing that bit can leave the fraction empty, and the pattern would then read as infinity. In that case the next fraction bit is set so that the result is still a NaN.

The block has one register stage, so results appear one clock after the operand is sampled. An asynchronous active-low reset clears all outputs.

Top module: `dp_nan_quiet`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero, whatever the operand is.
- R2: The class code is 0 for a zero (exponent field and fraction both zero), 1 for a denormal (exponent zero, fraction nonzero), 2 for a normal (exponent neither all zeros nor all ones) and 3 for an infinity (exponent 0x7FF, fraction zero). The sign bit does not affect the class.
- R3: An operand with exponent 0x7FF and a nonzero fraction is a NaN. It is signaling, class 5, when the mode bit XOR fraction bit 51 equals 1. Otherwise it is quiet, class 4. Mode 1 selects the 2008 encoding and mode 0 selects the legacy encoding.
- R4: In 2008 mode, the result for a signaling NaN is the operand with fraction bit 51 (word bit 51) set.
- R5: In legacy mode, the result for a signaling NaN is the operand with fraction bit 51 cleared.
- R6: In legacy mode, if clearing bit 51 leaves the fraction all zero, fraction bit 50 is also set, so the quieted result is always a NaN.
- R7: The signaling flag and the invalid flag are both 1 exactly when the operand is a signaling NaN. Quieting keeps the sign bit and every fraction bit other than those named in R4 to R6.
- R8: The result for any operand that is not a signaling NaN, quiet NaNs included, equals the operand bit for bit.
- R9: The outputs change only at a rising clock edge and reflect the operand and mode sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_2008_i | input | 1 | 1 selects the 2008 NaN encoding, 0 selects the legacy encoding |
| op_i | input | 64 | Double-precision operand |
| class_o | output | 3 | Class code, as given in R2 and R3 |
| snan_o | output | 1 | Operand was a signaling NaN |
| result_o | output | 64 | Quieted or passed-through value |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
There is only one register stage and no state is carried between operands. A wrong decision therefore shows at the ports one clock after the operand that triggered it, and it never shows later. An inverted mode sense would swap class codes 4 and 5 for a NaN and flip bit 51 of its result. A missing legacy repair would return an infinity pattern for a NaN whose only payload bit was bit 51. A stale or misrouted register would keep the previous result on the outputs after the operand has changed, or let it show up before the clock edge.

// File: rtl/dp_nan_quiet.sv
module dp_nan_quiet #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_2008_i,
  input  logic [EXP_W+FRAC_W:0]       op_i,
  output logic [2:0]                  class_o,
  output logic                        snan_o,
  output logic [EXP_W+FRAC_W:0]       result_o,
  output logic                        invalid_o
);

  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int QB = FRAC_W - 1;
  localparam int RB = FRAC_W - 2;
  localparam logic [FRAC_W-1:0] QMASK = FRAC_W'(1) << QB;
  localparam logic [FRAC_W-1:0] RMASK = FRAC_W'(1) << RB;

  localparam logic [2:0] CL_ZERO = 3'd0;
  localparam logic [2:0] CL_SUB  = 3'd1;
  localparam logic [2:0] CL_NORM = 3'd2;
  localparam logic [2:0] CL_INF  = 3'd3;
  localparam logic [2:0] CL_QNAN = 3'd4;
  localparam logic [2:0] CL_SNAN = 3'd5;

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  assign {sgn, ex, fr} = op_i;

  logic ex_ones, ex_zero, fr_nz, is_nan, is_snan;
  assign ex_ones = &ex;
  assign ex_zero = ~|ex;
  assign fr_nz   = |fr;
  assign is_nan  = ex_ones & fr_nz;
  assign is_snan = is_nan & (mode_2008_i ^ fr[QB]);

  logic [FRAC_W-1:0] fr_leg, fr_quiet;
  assign fr_leg   = fr & ~QMASK;
  assign fr_quiet = mode_2008_i ? (fr | QMASK)
                  : ((|fr_leg) ? fr_leg : (fr_leg | RMASK));

  logic [2:0] cls_d;
  always_comb begin
    if (ex_zero)     cls_d = fr_nz ? CL_SUB : CL_ZERO;
    else if (!ex_ones) cls_d = CL_NORM;
    else if (!fr_nz) cls_d = CL_INF;
    else             cls_d = is_snan ? CL_SNAN : CL_QNAN;
  end

  logic [W-1:0] res_d;
  assign res_d = is_snan ? {sgn, ex, fr_quiet} : op_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_o   <= CL_ZERO;
      snan_o    <= 1'b0;
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      class_o   <= cls_d;
      snan_o    <= is_snan;
      result_o  <= res_d;
      invalid_o <= is_snan;
    end
  end

  AST_SNAN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    snan_o |-> (class_o == CL_SNAN)); // R3

  AST_QUIET_IS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    snan_o |-> ((&result_o[W-2:FRAC_W]) && (|result_o[FRAC_W-1:0]))); // R6

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (result_o[W-1] == $past(op_i[W-1]))); // R7

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (snan_o || (result_o == $past(op_i)))); // R8

  AST_INV_ONLY_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (!invalid_o || (&$past(op_i[W-2:FRAC_W])))); // R7

  AST_LEGACY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (!(snan_o && !$past(mode_2008_i)) || !result_o[QB])); // R5

  AST_2008_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (!(snan_o && $past(mode_2008_i)) || result_o[QB])); // R4

endmodule

// File: tb/sim_dp_nan_quiet.sv
module sim_dp_nan_quiet;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [63:0] op = '0;
  logic [2:0]  cls;
  logic        snan, inv;
  logic [63:0] res;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  dp_nan_quiet u0 (
    .clk(clk), .rst_n(rst_n), .mode_2008_i(mode), .op_i(op),
    .class_o(cls), .snan_o(snan), .result_o(res), .invalid_o(inv)
  );

  // {mode, operand, class, signaling, expected result}
  localparam int NV = 19;
  localparam logic [132:0] VEC [NV] = '{
    {1'b1, 64'h0000000000000000, 3'd0, 1'b0, 64'h0000000000000000},
    {1'b0, 64'h8000000000000000, 3'd0, 1'b0, 64'h8000000000000000},
    {1'b1, 64'h0000000000000001, 3'd1, 1'b0, 64'h0000000000000001},
    {1'b0, 64'h800FFFFFFFFFFFFF, 3'd1, 1'b0, 64'h800FFFFFFFFFFFFF},
    {1'b0, 64'h0010000000000000, 3'd2, 1'b0, 64'h0010000000000000},
    {1'b1, 64'h3FF0000000000000, 3'd2, 1'b0, 64'h3FF0000000000000},
    {1'b0, 64'hFFEFFFFFFFFFFFFF, 3'd2, 1'b0, 64'hFFEFFFFFFFFFFFFF},
    {1'b1, 64'h7FF0000000000000, 3'd3, 1'b0, 64'h7FF0000000000000},
    {1'b0, 64'hFFF0000000000000, 3'd3, 1'b0, 64'hFFF0000000000000},
    {1'b1, 64'h7FF8000000000000, 3'd4, 1'b0, 64'h7FF8000000000000},
    {1'b1, 64'hFFFFFFFFFFFFFFFF, 3'd4, 1'b0, 64'hFFFFFFFFFFFFFFFF},
    {1'b1, 64'h7FF0000000000001, 3'd5, 1'b1, 64'h7FF8000000000001},
    {1'b1, 64'hFFF4000000000000, 3'd5, 1'b1, 64'hFFFC000000000000},
    {1'b0, 64'h7FF0000000000001, 3'd4, 1'b0, 64'h7FF0000000000001},
    {1'b0, 64'h7FF7FFFFFFFFFFFF, 3'd4, 1'b0, 64'h7FF7FFFFFFFFFFFF},
    {1'b0, 64'h7FF8000000000000, 3'd5, 1'b1, 64'h7FF4000000000000},
    {1'b0, 64'hFFF8000000000000, 3'd5, 1'b1, 64'hFFF4000000000000},
    {1'b0, 64'hFFF8000000000123, 3'd5, 1'b1, 64'hFFF0000000000123},
    {1'b0, 64'h7FFFFFFFFFFFFFFF, 3'd5, 1'b1, 64'h7FF7FFFFFFFFFFFF}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [2:0] ec, input logic es,
                         input logic [63:0] er);
    chk({tag, " R2 R3 class"}, 64'(cls), 64'(ec));
    chk({tag, " R7 signaling flag"}, 64'(snan), 64'(es));
    chk({tag, " R7 invalid flag"}, 64'(inv), 64'(es));
    chk({tag, " R4 R5 R6 R8 result"}, res, er);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset holds outputs at zero even with a signaling NaN on the input
    mode = 1'b1; op = 64'h7FF0000000000001;
    @(negedge clk);
    chk_all("R1 in reset", 3'd0, 1'b0, 64'h0);
    rst_n = 1'b1;
    chk_all("R1 release", 3'd0, 1'b0, 64'h0);

    for (int i = 0; i < NV; i++) begin
      mode = VEC[i][132]; op = VEC[i][131:68];
      @(negedge clk);
      chk_all($sformatf("vec%0d", i), VEC[i][67:65], VEC[i][64], VEC[i][63:0]);
    end

    // R9: a new operand does not show before the next rising edge
    mode = 1'b0; op = 64'h7FF8000000000000;
    @(negedge clk);
    mode = 1'b1; op = 64'h4000000000000000;
    #1;
    chk_all("R9 before edge", 3'd5, 1'b1, 64'h7FF4000000000000);
    @(negedge clk);
    chk_all("R9 after edge", 3'd2, 1'b0, 64'h4000000000000000);

    // R3: the same NaN flips class with the mode bit
    mode = 1'b0; op = 64'hFFF0000000000010;
    @(negedge clk);
    chk_all("R3 legacy quiet", 3'd4, 1'b0, 64'hFFF0000000000010);
    mode = 1'b1;
    @(negedge clk);
    chk_all("R3 2008 signaling", 3'd5, 1'b1, 64'hFFF8000000000010);

    // R1: reset asserted mid-run clears the outputs
    rst_n = 1'b0;
    #1;
    chk_all("R1 mid-run reset", 3'd0, 1'b0, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 resume", 3'd5, 1'b1, 64'hFFF8000000000010);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule